// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem status register of one channel of a 16550-style serial port. It watches four active-low handshake inputs from a modem or data set: clear-to-send, data-set-ready, ring indicator and carrier detect. It passes each input through a synchronizer and presents the inverted level of each one in the upper nibble of a status byte. Any input that asserts therefore reads back as a 1.

The lower nibble holds sticky change flags. Three of the flags latch on any change of their input. The ring flag latches only when the ring pin returns from low to high, which is the trailing edge of a ring indication. A CPU read, marked by a one-cycle read strobe, returns the byte as it stood before the read. The flags clear on the clock edge that closes the strobe cycle, except for any flag whose event lands in that same cycle. An interrupt request is raised while the interrupt enable is high and any flag is set.

Top module: `modem_status_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every change flag and the synchronizer state are cleared to the idle state (pins seen high). After reset with all pins high, `rd_data` reads 8'h00 and `irq` is low.
- R2: Bits 4, 5, 6 and 7 of `rd_data` read the complement of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively. A bit follows its pin two clock edges after the pin changes.
- R3: Bit 0 (`cts_n`), bit 1 (`dsr_n`) and bit 3 (`dcd_n`) set when their input changes in either direction. The flag is visible three clock edges after the pin change.
- R4: Bit 2 sets when `ri_n` goes from low to high. A high-to-low transition of `ri_n` leaves bit 2 clear.
- R5: A set flag stays set until a read. In the strobe cycle, `rd_data` returns the flag values from before the read. The flags clear at the clock edge that ends the strobe cycle.
- R6: A flag whose event coincides with the read strobe cycle is set after that read rather than lost.
- R7: `irq` is high exactly when `ien` is high and at least one of bits 0 to 3 is set. It falls once a read clears the flags.
- R8: A flag sets only for an input that changed. The flags of unchanged inputs stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| rd_strobe | input | 1 | One-cycle read of the status byte; clears the flags |
| ien | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status byte: [7:4] inverted levels, [3:0] change flags |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. A change flag rises only after its status bit has moved, and the ring flag rises only on the inverted bit falling. Flags never drop without a read. `irq` agrees with the enable and the flags. The bench sweeps all sixteen pin patterns in sequence, so the ring direction rule and the independence of the flags are covered. Only directed bench scenarios can show the read-time behaviours: a read returning the pre-read value, the clear after the strobe, and an event that collides with the strobe being kept.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int MSR_LINES = 4;
  localparam int LINE_CTS  = 0;
  localparam int LINE_DSR  = 1;
  localparam int LINE_RI   = 2;
  localparam int LINE_DCD  = 3;
  // lines whose flag latches only on a low-to-high pin transition
  localparam logic [MSR_LINES-1:0] RISE_ONLY_MASK = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < STAGES; j++) stg[j] <= IDLE;
    end else begin
      stg[0] <= din;
      for (int j = 1; j < STAGES; j++) stg[j] <= stg[j-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/msr_edge.sv
module msr_edge #(
  parameter int W = 4,
  parameter logic [W-1:0] RISE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (RISE_MASK[i]) begin : g_rise
      assign evt[i] = lvl[i] & ~prev[i];
    end else begin : g_any
      assign evt[i] = lvl[i] ^ prev[i];
    end
  end
endmodule

// File: rtl/msr_flags.sv
module msr_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)      flags <= '0;
    else if (clr) flags <= evt;
    else          flags <= flags | evt;
  end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       rd_strobe,
  input  logic       ien,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic [MSR_LINES-1:0] pins, lvl, evt, flags;

  assign pins[LINE_CTS] = cts_n;
  assign pins[LINE_DSR] = dsr_n;
  assign pins[LINE_RI]  = ri_n;
  assign pins[LINE_DCD] = dcd_n;

  msr_sync #(.W(MSR_LINES), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .dout(lvl)
  );

  msr_edge #(.W(MSR_LINES), .RISE_MASK(RISE_ONLY_MASK)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .evt(evt)
  );

  msr_flags #(.W(MSR_LINES)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .clr(rd_strobe), .flags(flags)
  );

  assign rd_data = {~lvl, flags};
  assign irq     = ien & (|flags);
endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_strobe,
  input logic       ien,
  input logic [7:0] rd_data,
  input logic       irq
);
  // R3: an any-direction flag rises only after its status bit moved
  assert_cts_change_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[0]) |-> ($past(rd_data[4]) != $past(rd_data[4], 2)));
  assert_dsr_change_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[1]) |-> ($past(rd_data[5]) != $past(rd_data[5], 2)));
  assert_dcd_change_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[3]) |-> ($past(rd_data[7]) != $past(rd_data[7], 2)));
  // R4: ring flag rises only after the inverted ring bit fell (pin went high)
  assert_ri_trailing_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[2]) |-> (!$past(rd_data[6]) && $past(rd_data[6], 2)));
  // R5: without a read, no flag drops
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));
  // R7: interrupt request agrees with enable and flags
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !ien |-> !irq);
  assert_irq_flags_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (ien && (rd_data[3:0] != 4'h0)));
endmodule

bind modem_status_reg modem_status_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .ien(ien),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pins = 4'hF;  // {dcd_n, ri_n, dsr_n, cts_n}
  logic rd_strobe = 1'b0;
  logic ien = 1'b0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  modem_status_reg u_modem_status_reg (
    .clk(clk), .rst(rst), .cts_n(pins[0]), .dsr_n(pins[1]),
    .ri_n(pins[2]), .dcd_n(pins[3]), .rd_strobe(rd_strobe), .ien(ien),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle read; returns the value seen in the strobe cycle
  task automatic do_read(output logic [7:0] v);
    rd_strobe = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    logic [3:0] prev;
    logic [3:0] expf;
    settle(3);
    rst = 1'b0;
    settle(1);
    check("R1 reset byte", rd_data, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);

    // sweep all pin patterns; expected flags from xor, ring only rising pin
    prev = 4'hF;
    for (int k = 0; k < 32; k++) begin
      logic [3:0] nv;
      nv = 4'((k * 7 + 3) % 16);
      pins = nv;
      settle(4);
      expf = (prev ^ nv) & 4'b1011;
      expf[2] = !prev[2] && nv[2];
      do_read(v);
      check("R2 R3 R4 R8 sweep", v, {~nv, expf});
      do_read(v);
      check("R5 cleared after read", v, {~nv, 4'h0});
      prev = nv;
    end

    // ring falling only
    pins = 4'hF; settle(4); do_read(v);
    pins = 4'hB; settle(4); do_read(v);
    check("R4 ring fall ignored", v, 8'h40);
    pins = 4'hF; settle(4); do_read(v);
    check("R4 ring rise sets", v, 8'h04);

    // sticky and irq
    ien = 1'b1;
    pins = 4'hE; settle(4);
    check("R7 irq high", {7'd0, irq}, 8'h01);
    settle(10);
    check("R5 sticky", rd_data, 8'h11);
    do_read(v);
    check("R5 pre-read value", v, 8'h11);
    #1 check("R7 irq cleared", {7'd0, irq}, 8'h00);
    pins = 4'hF; settle(4);
    ien = 1'b0; #1;
    check("R7 irq gated off", {7'd0, irq}, 8'h00);
    ien = 1'b1; #1;
    check("R7 irq re-enabled", {7'd0, irq}, 8'h01);
    do_read(v);

    // event in the same cycle as the read
    pins = 4'hD;           // dsr asserts; event in cycle after two edges
    @(negedge clk);
    @(negedge clk);
    do_read(v);
    check("R6 read during event", v, 8'h20);
    do_read(v);
    check("R6 event kept", v, 8'h22);

    // reset mid-state
    pins = 4'hF; settle(4);
    rst = 1'b1; settle(2); rst = 1'b0; settle(1);
    check("R1 reset clears flags", rd_data, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule